// File: doc/BRIEF.md
# Multi-mode address pattern generator

This block supplies the command addresses of a memory traffic generator. Software-free and purely reactive, it is restarted by a one-cycle load pulse, which captures a mode and a start address. From then on it presents one address at a time on a valid/ready output stream. Each accepted transfer moves it to the next address of the selected pattern.

The generated part of the address is a field of N = ADDR_W - 3 bits placed above three low bits that are always zero, so every address is aligned to an eight-unit command boundary. One state register of N bits is shared by four patterns:
- a linear count starting from a given address;
- a maximal-length pseudo-random (LFSR) sequence;
- a single one walking through a field of zeros;
- a single zero walking through a field of ones.

The linear pattern repeats after 2^N addresses, the LFSR after 2^N - 1 (zero is never produced) and the walking patterns after N. The LFSR polynomial is chosen from the field width, which may range from 8 to 34 bits.

Output stream rules: `addr_valid` stays high from the cycle after an accepted load until the next load. While `addr_valid` is high and `addr_ready` is low, `addr` is held unchanged. There is no combinational path from `addr_ready` to any output. A load has priority over a handshake in the same cycle.

Top module: `addr_pattern_gen`

## Requirements
- R1: After reset `addr_valid` is 0 and `addr` is 0, and both stay so until a load.
- R2: A load with mode 0 (linear) makes `addr_valid` 1 in the next cycle with `addr` = start_addr with its three low bits cleared; the start address's low three bits are ignored.
- R3: In linear mode each handshake (`addr_valid` and `addr_ready` both 1) raises `addr` by 8, wrapping from 2^ADDR_W - 8 to 0, giving 2^N distinct addresses.
- R4: A load with mode 1 (PRBS) gives the field value 1 (address 8) first. Each handshake shifts the field left by one, and the new bit 0 is the XOR of the field bits at the tap positions. For a 13-bit field these are bits 12, 3, 2 and 0. The field is never zero and returns to 1 after exactly 2^N - 1 handshakes.
- R5: A load with mode 2 (walking one) gives field value 1 first. Each handshake rotates the field left by one position, so the pattern returns after N handshakes.
- R6: A load with mode 3 (walking zero) gives a field with only bit 0 cleared first. Each handshake rotates the field left by one, with period N.
- R7: While `addr_valid` is 1 and `addr_ready` is 0, `addr` and `addr_valid` keep their values in the next cycle.
- R8: A load with a mode value of 4 to 15 drives `addr_valid` to 0 from the next cycle until the next load with a valid mode.
- R9: A load in the same cycle as a handshake restarts the pattern from the newly loaded mode and start, ignoring the handshake.
- R10: The three low bits of `addr` are 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | One-cycle restart pulse capturing mode and start address |
| mode | input | 4 | Pattern select: 0 linear, 1 PRBS, 2 walking one, 3 walking zero, 4-15 reserved |
| start_addr | input | ADDR_W | Start address for linear mode |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | An address is offered |
| addr | output | ADDR_W | Current command address |

## Verification
The hardest state to reach from the ports is the end of the pseudo-random period, where the field comes back to its seed after 8191 handshakes at the default width. The bench reaches it by holding ready high through one whole period, counting cycles until address 8 reappears, while a behavioural model compares every address on the way. The linear wrap from the top address to zero is reached by loading a start address a few steps below it. Random back-pressure is applied in every mode so that stalls land at varied positions within each pattern.

// File: rtl/apg_pkg.sv
package apg_pkg;

  typedef enum logic [3:0] {
    MODE_LINEAR = 4'd0,
    MODE_PRBS   = 4'd1,
    MODE_WALK1  = 4'd2,
    MODE_WALK0  = 4'd3
  } apg_mode_e;

  localparam int MAX_POLY = 34;

  function automatic logic [MAX_POLY-1:0] tap_bit(input int pos);
    logic [MAX_POLY-1:0] m;
    m = '0;
    if (pos > 0) m[pos-1] = 1'b1;
    return m;
  endfunction

  function automatic logic [MAX_POLY-1:0] taps4(input int a, input int b,
                                                input int c, input int d);
    return tap_bit(a) | tap_bit(b) | tap_bit(c) | tap_bit(d);
  endfunction

  // Feedback mask of a maximal-length polynomial for each supported length.
  function automatic logic [MAX_POLY-1:0] prbs_taps(input int len);
    case (len)
      8:  return taps4(8, 6, 5, 4);
      9:  return taps4(9, 5, 0, 0);
      10: return taps4(10, 7, 0, 0);
      11: return taps4(11, 9, 0, 0);
      12: return taps4(12, 6, 4, 1);
      13: return taps4(13, 4, 3, 1);
      14: return taps4(14, 5, 3, 1);
      15: return taps4(15, 14, 0, 0);
      16: return taps4(16, 15, 13, 4);
      17: return taps4(17, 14, 0, 0);
      18: return taps4(18, 11, 0, 0);
      19: return taps4(19, 6, 2, 1);
      20: return taps4(20, 17, 0, 0);
      21: return taps4(21, 19, 0, 0);
      22: return taps4(22, 21, 0, 0);
      23: return taps4(23, 18, 0, 0);
      24: return taps4(24, 23, 22, 17);
      25: return taps4(25, 22, 0, 0);
      26: return taps4(26, 6, 2, 1);
      27: return taps4(27, 5, 2, 1);
      28: return taps4(28, 25, 0, 0);
      29: return taps4(29, 27, 0, 0);
      30: return taps4(30, 6, 4, 1);
      31: return taps4(31, 28, 0, 0);
      32: return taps4(32, 22, 2, 1);
      33: return taps4(33, 20, 0, 0);
      34: return taps4(34, 27, 2, 1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/apg_lfsr_step.sv
module apg_lfsr_step #(
  parameter int FIELD_W = 13
) (
  input  logic [FIELD_W-1:0] cur,
  output logic [FIELD_W-1:0] nxt
);
  import apg_pkg::*;

  localparam logic [MAX_POLY-1:0] FULL_MASK = prbs_taps(FIELD_W);
  localparam logic [FIELD_W-1:0]  MASK      = FULL_MASK[FIELD_W-1:0];

  logic fb;

  always_comb begin
    fb  = ^(cur & MASK);
    nxt = {cur[FIELD_W-2:0], fb};
  end
endmodule

// File: rtl/apg_next_state.sv
module apg_next_state #(
  parameter int FIELD_W = 13
) (
  input  apg_pkg::apg_mode_e   mode,
  input  logic [FIELD_W-1:0]   cur,
  output logic [FIELD_W-1:0]   nxt
);
  import apg_pkg::*;

  logic [FIELD_W-1:0] prbs_nxt;
  logic [FIELD_W-1:0] rot_nxt;
  logic [FIELD_W-1:0] lin_nxt;

  apg_lfsr_step #(.FIELD_W(FIELD_W)) u_lfsr (
    .cur (cur),
    .nxt (prbs_nxt)
  );

  always_comb begin
    rot_nxt = {cur[FIELD_W-2:0], cur[FIELD_W-1]};
    lin_nxt = cur + FIELD_W'(1);
    case (mode)
      MODE_LINEAR: nxt = lin_nxt;
      MODE_PRBS:   nxt = prbs_nxt;
      MODE_WALK1,
      MODE_WALK0:  nxt = rot_nxt;
      default:     nxt = cur;
    endcase
  end
endmodule

// File: rtl/addr_pattern_gen.sv
module addr_pattern_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr
);
  import apg_pkg::*;

  localparam int LOW_W   = 3;
  localparam int FIELD_W = ADDR_W - LOW_W;
  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  apg_mode_e          mode_q;
  logic               valid_q;
  logic [FIELD_W-1:0] state_q;
  logic [FIELD_W-1:0] step_nxt;
  logic [FIELD_W-1:0] seed;
  logic               load_ok;
  logic               fire;

  apg_next_state #(.FIELD_W(FIELD_W)) u_next (
    .mode (mode_q),
    .cur  (state_q),
    .nxt  (step_nxt)
  );

  always_comb begin
    load_ok = (mode[3:2] == 2'b00);
    fire    = valid_q & addr_ready;
    case (mode)
      4'd0:    seed = start_addr[ADDR_W-1:LOW_W];
      4'd1:    seed = ONE;
      4'd2:    seed = ONE;
      4'd3:    seed = ~ONE;
      default: seed = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_LINEAR;
      valid_q <= 1'b0;
      state_q <= '0;
    end else if (load) begin
      valid_q <= load_ok;
      if (load_ok) begin
        mode_q  <= apg_mode_e'(mode);
        state_q <= seed;
      end
    end else if (fire) begin
      state_q <= step_nxt;
    end
  end

  assign addr_valid = valid_q;
  assign addr       = {state_q, {LOW_W{1'b0}}};

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !load) |=> (addr_valid && $stable(addr)));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && !load && mode_q == MODE_LINEAR)
      |=> (addr == $past(addr) + ADDR_W'(8)));

  // R4
  prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && mode_q == MODE_PRBS) |-> (addr != '0));

  // R5
  walk1_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && mode_q == MODE_WALK1) |-> ($countones(addr) == 1));

  // R6
  walk0_single_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && mode_q == MODE_WALK0) |-> ($countones(addr) == FIELD_W - 1));

  // R8
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode[3:2] != 2'b00) |=> !addr_valid);

  // R2
  linear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == 4'd0)
      |=> (addr_valid && addr == {$past(start_addr[ADDR_W-1:LOW_W]), {LOW_W{1'b0}}}));
endmodule

// File: tb/tb_addr_pattern_gen.sv
`timescale 1ns/1ps
module tb_addr_pattern_gen;
  localparam int ADDR_W = 16;
  localparam int FW     = ADDR_W - 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load = 1'b0;
  logic [3:0]        mode = 4'd0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              addr_ready = 1'b0;
  logic              addr_valid;
  logic [ADDR_W-1:0] addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_valid = 0;
  int          m_mode  = 0;
  logic [FW-1:0] m_field = '0;

  always #10 clk = ~clk;

  addr_pattern_gen #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .mode(mode),
    .start_addr(start_addr), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .addr(addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [FW-1:0] model_step(input int md, input logic [FW-1:0] f);
    logic b;
    case (md)
      0: return f + 1;
      1: begin b = f[12] ^ f[3] ^ f[2] ^ f[0]; return {f[FW-2:0], b}; end
      default: return {f[FW-2:0], f[FW-1]};
    endcase
  endfunction

  // reference model, updated at the active edge from stable inputs
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_valid = 0; m_mode = 0; m_field = '0;
    end else if (load) begin
      if (mode < 4) begin
        m_valid = 1;
        m_mode  = int'(mode);
        case (mode)
          4'd0: m_field = start_addr[ADDR_W-1:3];
          4'd1, 4'd2: m_field = 1;
          default: m_field = ~FW'(1);
        endcase
      end else begin
        m_valid = 0;
      end
    end else if (m_valid && addr_ready) begin
      m_field = model_step(m_mode, m_field);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, 64'(addr_valid), 64'(m_valid));
      chk("R10", 64'(addr[2:0]), 64'd0);
      if (m_valid) chk(cur_req, 64'(addr), 64'({m_field, 3'b000}));
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_load(input logic [3:0] md, input logic [ADDR_W-1:0] sa);
    @(negedge clk);
    load = 1'b1; mode = md; start_addr = sa;
    @(negedge clk);
    load = 1'b0; mode = 4'd0; start_addr = '0;
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      addr_ready = $urandom_range(0, 1);
      @(negedge clk);
    end
    addr_ready = 1'b0;
  endtask

  task automatic period_check(input string req, input logic [ADDR_W-1:0] first, input int exp);
    int cnt = 0;
    addr_ready = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
    end while (addr !== first && cnt < 9000);
    addr_ready = 1'b0;
    chk(req, 64'(cnt), 64'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state held
    chk("R1", 64'(addr_valid), 64'd0);
    chk("R1", 64'(addr), 64'd0);
    rst_n = 1'b1;
    addr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", 64'(addr_valid), 64'd0);
    chk("R1", 64'(addr), 64'd0);
    addr_ready = 1'b0;

    // R2: linear start, low bits ignored
    cur_req = "R2";
    do_load(4'd0, 16'hFFE5);
    chk("R2", 64'(addr), 64'hFFE0);
    chk("R2", 64'(addr_valid), 64'd1);

    // R3: linear steps across the wrap
    cur_req = "R3";
    addr_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", 64'(addr), 64'h0000);
    @(negedge clk);
    chk("R3", 64'(addr), 64'h0008);
    addr_ready = 1'b0;

    // R7: back-pressure in linear mode
    cur_req = "R7";
    repeat (2) @(negedge clk);
    chk("R7", 64'(addr), 64'h0008);
    run_random(40);

    // R4: PRBS first value and full period
    cur_req = "R4";
    do_load(4'd1, 16'h1234);
    chk("R4", 64'(addr), 64'h0008);
    period_check("R4", 16'h0008, 8191);
    run_random(40);

    // R5: walking one
    cur_req = "R5";
    do_load(4'd2, '0);
    chk("R5", 64'(addr), 64'h0008);
    addr_ready = 1'b1;
    @(negedge clk);
    addr_ready = 1'b0;
    chk("R5", 64'(addr), 64'h0010);
    period_check("R5", 16'h0010, FW);
    run_random(40);

    // R6: walking zero
    cur_req = "R6";
    do_load(4'd3, '0);
    chk("R6", 64'(addr), 64'hFFF0);
    period_check("R6", 16'hFFF0, FW);
    run_random(40);

    // R8: reserved mode idles the stream
    cur_req = "R8";
    do_load(4'd9, 16'h0040);
    chk("R8", 64'(addr_valid), 64'd0);
    addr_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", 64'(addr_valid), 64'd0);
    addr_ready = 1'b0;
    do_load(4'd15, '0);
    chk("R8", 64'(addr_valid), 64'd0);

    // R9: load during a handshake restarts the pattern
    cur_req = "R9";
    do_load(4'd0, 16'h0100);
    addr_ready = 1'b1;
    repeat (3) @(negedge clk);
    load = 1'b1; mode = 4'd0; start_addr = 16'h0200;
    @(negedge clk);
    load = 1'b0;
    chk("R9", 64'(addr), 64'h0200);
    @(negedge clk);
    chk("R9", 64'(addr), 64'h0208);
    load = 1'b1; mode = 4'd2;
    @(negedge clk);
    load = 1'b0; mode = 4'd0;
    chk("R9", 64'(addr), 64'h0008);
    addr_ready = 1'b0;
    run_random(30);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule